// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external 16-bit-wide asynchronous static RAM. Every request carries an address, write data and a two-bit lane mask. The block turns it into a sequence of active-low memory strobes, timed in clock cycles. The cycle counts are derived from the memory's access time, write pulse width and data setup time, all given as parameters in picoseconds together with the clock period.

Reads assert chip select, output enable and the selected byte enables. The bus is sampled on the last cycle of the read, and the data comes back with a one-cycle valid pulse. Writes use a setup cycle, a write-enable pulse and a hold cycle. The data bus is driven only while output enable is high, so the controller and the memory never drive the bus at the same time. The data bus is split into an output value, an output-enable flag and an input value, ready for a pad ring.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset, every memory strobe is high, `mem_dq_oe` and `rsp_valid` are low and `req_ready` is high.
- R2: A read with a non-zero mask holds `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for RD_CYC = ceil(ACC_PS/CLK_PS)+1 cycles (4 with defaults). `rsp_valid` is seen high one cycle after the strobes end.
- R3: During an access, mask bit 0 drives `mem_lb_n` low (data bits 7:0) and mask bit 1 drives `mem_ub_n` low (data bits 15:8). In `rsp_rdata`, the lanes that were not read return zero.
- R4: A write with a non-zero mask uses one setup cycle with chip select and byte enables low and write enable high. It then holds write enable low for WP_CYC = max(ceil(WP_PS/CLK_PS), ceil(DSU_PS/CLK_PS)) cycles (2 with defaults), then uses one hold cycle. Chip select is low for WP_CYC+2 cycles in total.
- R5: `mem_oe_n` stays high for the whole of every write, and `mem_dq_oe` is never high while `mem_oe_n` is low.
- R6: `mem_dq_oe` goes high together with the fall of write enable and stays high through the hold cycle. The memory therefore sees valid write data when write enable rises.
- R7: Address and byte enables do not change while chip select stays low.
- R8: A request with mask 00 issues no strobe and keeps `req_ready` high. A read returns `rsp_valid` on the next cycle with data 0000, and a write leaves the memory unchanged.
- R9: `req_ready` is low for the whole of a memory access. A `req_valid` raised while `req_ready` is low is ignored.
- R10: A write updates only the lanes selected by its mask. Later reads return the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 1 = upper byte, bit 0 = lower byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unread lanes zero |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory pins |

## Verification
The assertions assume `rst_n` is held low across the first clock edges. They also assume requests are presented only as whole-cycle pulses, so the controller's strobes depend on its own state alone.

The bench drives every input on the falling edge and never changes `req_valid` in the middle of a cycle. Its memory model returns a poison pattern until the strobes have stayed active for the access time. A read that samples too early is therefore caught by the data check rather than by an assertion.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW     = 16,
  parameter int CLK_PS = 4000,
  parameter int ACC_PS = 12000,
  parameter int WP_PS  = 8000,
  parameter int DSU_PS = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);
  localparam int RD_CYC  = (ACC_PS + CLK_PS - 1) / CLK_PS + 1;
  localparam int WP_A    = (WP_PS + CLK_PS - 1) / CLK_PS;
  localparam int WP_B    = (DSU_PS + CLK_PS - 1) / CLK_PS;
  localparam int WP_MAX  = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int WP_CYC  = (WP_MAX < 1) ? 1 : WP_MAX;
  localparam int CNT_MAX = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSU, S_WP, S_WH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [1:0]    mask_q;
  logic [15:0]   lane_keep;

  assign lane_keep  = {{8{mask_q[1]}}, {8{mask_q[0]}}};
  assign req_ready  = (st == S_IDLE);
  assign mem_cs_n   = (st == S_IDLE);
  assign mem_oe_n   = (st != S_RD);
  assign mem_we_n   = (st != S_WP);
  assign mem_lb_n   = mem_cs_n | ~mask_q[0];
  assign mem_ub_n   = mem_cs_n | ~mask_q[1];
  assign mem_dq_oe  = (st == S_WP) || (st == S_WH);
  assign mem_dq_out = data_q;
  assign mem_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_mask == 2'b00) begin
            if (!req_we) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
            end
          end else begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            mask_q <= req_mask;
            if (req_we) begin
              st <= S_WSU;
            end else begin
              st  <= S_RD;
              cnt <= CW'(RD_CYC - 1);
            end
          end
        end
        S_RD: if (cnt == '0) begin
          rsp_rdata <= mem_dq_in & lane_keep;
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WSU: begin
          st  <= S_WP;
          cnt <= CW'(WP_CYC - 1);
        end
        S_WP: if (cnt == '0) st <= S_WH;
              else           cnt <= cnt - 1'b1;
        S_WH: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic          mem_dq_oe
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  // R5
  write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  // R4
  write_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && !(mem_ub_n && mem_lb_n)));
  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_cs_n));
  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe));
  // R6
  drive_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |->
      ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));
  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
  // R2
  rsp_after_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_cs_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int CLK_PS = 4000, ACC_PS = 12000, WP_PS = 8000, DSU_PS = 6000;
  localparam int RD  = (ACC_PS + CLK_PS - 1) / CLK_PS + 1;
  localparam int WPA = (WP_PS + CLK_PS - 1) / CLK_PS;
  localparam int WPB = (DSU_PS + CLK_PS - 1) / CLK_PS;
  localparam int WP  = (WPA > WPB) ? WPA : WPB;
  localparam int ACC = (ACC_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_ready, rsp_valid;
  logic [15:0] req_addr = 0, req_wdata = 0, rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic [1:0] req_mask = 0;
  logic mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sram_lane_ctrl #(.AW(16), .CLK_PS(CLK_PS), .ACC_PS(ACC_PS), .WP_PS(WP_PS), .DSU_PS(DSU_PS)) u0 (.*);

  logic [15:0] mem [256];
  int acc;
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(posedge mem_we_n)
    if (rst_n && !mem_cs_n) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : 8'h5A;
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq_oe ? mem_dq_out[15:8] : 8'h5A;
    end

  always @(posedge clk)
    acc <= (!mem_cs_n && !mem_oe_n && mem_we_n) ? acc + 1 : 0;

  assign mem_dq_in = (mem_cs_n || mem_oe_n) ? 16'hDEAD :
                     (acc < ACC) ? 16'hBAD0 :
                     {mem_ub_n ? 8'hDE : mem[mem_addr[7:0]][15:8],
                      mem_lb_n ? 8'hAD : mem[mem_addr[7:0]][7:0]};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [1:0] mask, input logic [15:0] addr,
                      input logic [15:0] wdata, input logic [15:0] exp);
    int n = 0, cs_lo = 0, we_lo = 0, oe_lo = 0, rsp_at = 0, lane_bad = 0, contend = 0, busy = 0;
    logic [15:0] got = 16'hFFFF;
    @(negedge clk);
    req_valid = 1; req_we = we; req_mask = mask; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 0; req_addr = ~addr; req_wdata = ~wdata;
    for (int k = 0; k < 20; k++) begin
      n++;
      if (!mem_cs_n) begin
        cs_lo++;
        if (mem_lb_n !== !mask[0] || mem_ub_n !== !mask[1]) lane_bad++;
      end
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (!req_ready) busy++;
      if (mem_dq_oe && !mem_oe_n) contend++;
      if (rsp_valid) begin rsp_at = n; got = rsp_rdata; end
      if (req_ready && (we || rsp_at != 0)) break;
      @(negedge clk);
    end
    if (mask == 2'b00) begin
      chk("R8 no strobe on empty mask", cs_lo, 0);
      chk("R8 ready kept high", busy, 0);
      if (!we) chk("R8 empty read latency", rsp_at, 1);
    end else if (we) begin
      chk("R4 select cycles", cs_lo, WP + 2);
      chk("R4 write pulse cycles", we_lo, WP);
      chk("R5 oe high in write", oe_lo, 0);
      chk("R9 busy cycles", busy, WP + 2);
    end else begin
      chk("R2 read strobe cycles", oe_lo, RD);
      chk("R2 read cs cycles", cs_lo, RD);
      chk("R2 rsp timing", rsp_at, RD + 1);
    end
    chk("R3 lane enables", lane_bad, 0);
    chk("R5 no contention", contend, 0);
    if (!we) chk("R10 R3 read data", got, exp);
  endtask

  localparam logic [50:0] VEC [12] = '{
    {1'b1, 2'b11, 16'h0010, 16'hA5A5, 16'h0000},
    {1'b1, 2'b11, 16'h0011, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'hA5A5},
    {1'b1, 2'b01, 16'h0010, 16'h00FF, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'hA5FF},
    {1'b1, 2'b10, 16'h0010, 16'h7700, 16'h0000},
    {1'b0, 2'b01, 16'h0010, 16'h0000, 16'h00FF},
    {1'b0, 2'b10, 16'h0010, 16'h0000, 16'h7700},
    {1'b0, 2'b11, 16'h0011, 16'h0000, 16'h1234},
    {1'b1, 2'b00, 16'h0011, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 16'h0011, 16'h0000, 16'h1234},
    {1'b0, 2'b00, 16'h0011, 16'h0000, 16'h0000}
  };

  initial begin
    #600000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b11111);
    chk("R1 ready/valid/oe in reset", {req_ready, rsp_valid, mem_dq_oe}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);

    foreach (VEC[i])
      xfer(VEC[i][50], VEC[i][49:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);

    // R9: request raised while busy is ignored
    @(negedge clk);
    req_valid = 1; req_we = 1; req_mask = 2'b11; req_addr = 16'h0020; req_wdata = 16'h1111;
    @(negedge clk);
    req_addr = 16'h0021; req_wdata = 16'h2222;
    repeat (WP + 1) @(negedge clk);
    chk("R9 still busy", req_ready, 1'b0);
    req_valid = 0;
    @(negedge clk);
    chk("R9 ready back", req_ready, 1'b1);
    xfer(1'b0, 2'b11, 16'h0021, 16'h0000, 16'h0000);
    xfer(1'b0, 2'b11, 16'h0020, 16'h0000, 16'h1111);

    // R8: empty write leaves memory alone, R6: write data landed
    xfer(1'b1, 2'b00, 16'h0020, 16'hBEEF, 16'h0000);
    xfer(1'b0, 2'b11, 16'h0020, 16'h0000, 16'h1111);

    // R7 R6: back-to-back writes at different addresses
    xfer(1'b1, 2'b11, 16'h00FE, 16'hCAFE, 16'h0000);
    xfer(1'b1, 2'b11, 16'h00FF, 16'hF00D, 16'h0000);
    xfer(1'b0, 2'b11, 16'h00FE, 16'h0000, 16'hCAFE);
    xfer(1'b0, 2'b11, 16'h00FF, 16'h0000, 16'hF00D);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule